// File: doc/BRIEF.md
# Debug Event Counter with Trace Tagging

This block is the event counter of a processor core's debug unit. Software loads a 32-bit count value and a 16-bit control word. Each time the selected event occurs, the count goes down by one. The event can be a core clock cycle, a word handed to the trace writer, or a start-address comparator hit. Counting can begin at once, or it can be armed so that it starts only when the start-address comparator fires. A match on the end-address comparator can raise a debug exception request. The handler then stops the counter and reads it back. The elapsed cycle count is the loaded value minus the value read.

The block also sits in the trace path. It accepts each traced destination address and passes it to the trace writer. Depending on the control word, it follows the address with a snapshot of the count and, optionally, a snapshot of the extension counter. In extended mode the two 32-bit registers form one cascaded counter: an underflow of the main count takes one from the extension count. When the source is trace words, the inserted counter words are counted like any other word.

Top module: `dbg_event_counter`

## Requirements
- R1: After reset the control word, count and extension registers read zero, no trace word is offered, and no exception request is raised.
- R2: A control write stores bits 9..0. Bits 15..10 are ignored on write and always read as zero. The field layout is: bits 1..0 enable mode, bits 4..2 event source, bit 5 exception on end match, bits 7..6 trace mode, bit 8 extended mode, bit 9 test.
- R3: Enable mode 00 or 11 holds the count. Mode 01 counts every selected event from the cycle after the control write. Mode 10 counts only after a start match, with the first count at the clock edge after the match cycle; a control write disarms it.
- R4: Source 000 counts every clock cycle. Source 001 counts each word accepted by the trace writer. Source 010 counts start-match pulses. Sources 011..111 count nothing.
- R5: A software write to the count register (select 1) or the extension register (select 2) wins over an event in the same cycle. The written value is what reads back.
- R6: In regular mode the count stops at zero and does not wrap.
- R7: In extended mode, an event that finds the count at zero and the extension nonzero loads the count with all ones and takes one from the extension. When both are zero the pair holds at zero.
- R8: An end match while bit 5 is set drives the exception request high for exactly the next cycle. Otherwise the request stays low.
- R9: Each accepted address produces, in this order, the address word, then the count word when the trace mode is nonzero, then the extension word when trace mode bit 7 is set. The address is accepted only when no word is pending, and a stalled word holds its data.
- R10: The count and extension words carry the register values held in the cycle in which the address word was accepted.
- R11: The test bit reads back as written and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_sel | input | 2 | Write target: 0 control, 1 count, 2 extension, 3 none |
| csr_wr_data | input | 32 | Write data |
| csr_rd_sel | input | 2 | Read select: 0 control (zero-extended), 1 count, 2 extension, 3 zero |
| csr_rd_data | output | 32 | Read data |
| start_match | input | 1 | Start-address comparator hit pulse |
| end_match | input | 1 | End-address comparator hit pulse |
| dbg_exc_req | output | 1 | Debug exception request pulse |
| trc_in_valid | input | 1 | Traced destination address available |
| trc_in_addr | input | 32 | Traced destination address |
| trc_in_ready | output | 1 | Address accepted |
| trc_out_valid | output | 1 | Trace word valid toward the writer |
| trc_out_data | output | 32 | Trace word |
| trc_out_ready | input | 1 | Writer accepts the word |

## Verification
The hardest situation to reach is a main-count underflow into the extension register that is triggered by the block's own inserted trace words. That underflow must also land between the snapshot and the emission of the words of a later packet. The bench gets there by loading the count with 1 and the extension with 5 through the write port. It selects trace words as the source with full trace mode in extended mode, and sends packets while the writer's ready toggles. A reference model of the cascade predicts every count and extension word in the scoreboard.

// File: rtl/evc_pkg.sv
package evc_pkg;

  localparam int CTRL_W = 16;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 16'h03FF;

  localparam logic [1:0] EN_OFF      = 2'd0;
  localparam logic [1:0] EN_NOW      = 2'd1;
  localparam logic [1:0] EN_ON_START = 2'd2;

  localparam logic [2:0] SRC_CLOCK = 3'd0;
  localparam logic [2:0] SRC_TRACE = 3'd1;
  localparam logic [2:0] SRC_START = 3'd2;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_EXT  = 2'd2;

  typedef struct packed {
    logic [5:0] rsvd;
    logic       test;
    logic       ext_mode;
    logic [1:0] trace_mode;
    logic       exc_en;
    logic [2:0] src;
    logic [1:0] en;
  } ctrl_t;

  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_ADDR = 2'd1,
    TS_CNT  = 2'd2,
    TS_EXT  = 2'd3
  } trc_state_e;

  function automatic ctrl_t ctrl_clean(input logic [CTRL_W-1:0] raw);
    return ctrl_t'(raw & CTRL_KEEP);
  endfunction

  function automatic logic src_event(input logic [2:0] src,
                                     input logic word_fire,
                                     input logic start_hit);
    case (src)
      SRC_CLOCK: return 1'b1;
      SRC_TRACE: return word_fire;
      SRC_START: return start_hit;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evc_ctrl_reg.sv
module evc_ctrl_reg
  import evc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              start_match,
  output ctrl_t             ctrl_q,
  output logic              count_active
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q  <= ctrl_clean(wr_data);
        armed_q <= 1'b0;
      end else if (ctrl_q.en == EN_ON_START && start_match) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    count_active = (ctrl_q.en == EN_NOW) ||
                   (ctrl_q.en == EN_ON_START && armed_q);
  end

endmodule

// File: rtl/evc_count_core.sv
module evc_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt,
  input  logic             wr_ext,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             step,
  input  logic             ext_mode,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] ext_q,
  output logic             borrow
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] main_next(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] e,
                                                 input logic cascade);
    if (c != '0)                  return c - ONE;
    else if (cascade && e != '0)  return ALL_ONES;
    else                          return '0;
  endfunction

  logic cnt_zero;
  assign cnt_zero = (cnt_q == '0);
  assign borrow   = step && cnt_zero && ext_mode && (ext_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (wr_cnt) begin
      cnt_q <= wr_data;
    end else if (step) begin
      cnt_q <= main_next(cnt_q, ext_q, ext_mode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= '0;
    end else if (wr_ext) begin
      ext_q <= wr_data;
    end else if (borrow && !wr_cnt) begin
      ext_q <= ext_q - ONE;
    end
  end

endmodule

// File: rtl/evc_trace_seq.sv
module evc_trace_seq
  import evc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_addr,
  output logic              in_ready,
  input  logic [1:0]        trace_mode,
  input  logic [DATA_W-1:0] cnt_in,
  input  logic [DATA_W-1:0] ext_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              word_fire
);

  trc_state_e        state_q;
  logic [1:0]        tm_q;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] cnt_snap;
  logic [DATA_W-1:0] ext_snap;

  assign in_ready  = (state_q == TS_IDLE);
  assign out_valid = (state_q != TS_IDLE);
  assign word_fire = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TS_IDLE;
      tm_q     <= '0;
      addr_q   <= '0;
      cnt_snap <= '0;
      ext_snap <= '0;
    end else begin
      case (state_q)
        TS_IDLE: if (in_valid) begin
          addr_q  <= in_addr;
          tm_q    <= trace_mode;
          state_q <= TS_ADDR;
        end
        TS_ADDR: if (out_ready) begin
          cnt_snap <= cnt_in;
          ext_snap <= ext_in;
          state_q  <= (tm_q == 2'd0) ? TS_IDLE : TS_CNT;
        end
        TS_CNT: if (out_ready) begin
          state_q <= tm_q[1] ? TS_EXT : TS_IDLE;
        end
        default: if (out_ready) begin
          state_q <= TS_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (state_q)
      TS_CNT:  out_data = cnt_snap;
      TS_EXT:  out_data = ext_snap;
      default: out_data = addr_q;
    endcase
  end

endmodule

// File: rtl/dbg_event_counter.sv
module dbg_event_counter
  import evc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr_en,
  input  logic [1:0]       csr_wr_sel,
  input  logic [CNT_W-1:0] csr_wr_data,
  input  logic [1:0]       csr_rd_sel,
  output logic [CNT_W-1:0] csr_rd_data,
  input  logic             start_match,
  input  logic             end_match,
  output logic             dbg_exc_req,
  input  logic             trc_in_valid,
  input  logic [CNT_W-1:0] trc_in_addr,
  output logic             trc_in_ready,
  output logic             trc_out_valid,
  output logic [CNT_W-1:0] trc_out_data,
  input  logic             trc_out_ready
);

  localparam int PAD_W = CNT_W - CTRL_W;

  logic             wr_ctrl, wr_cnt, wr_ext;
  ctrl_t            ctrl_q;
  logic [CTRL_W-1:0] ctrl_word;
  logic             count_active;
  logic             word_fire;
  logic             evt_hit;
  logic             step;
  logic             borrow;
  logic [CNT_W-1:0] cnt_q, ext_q;

  assign wr_ctrl   = csr_wr_en && (csr_wr_sel == SEL_CTRL);
  assign wr_cnt    = csr_wr_en && (csr_wr_sel == SEL_CNT);
  assign wr_ext    = csr_wr_en && (csr_wr_sel == SEL_EXT);
  assign ctrl_word = ctrl_q;

  evc_ctrl_reg u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ctrl      (wr_ctrl),
    .wr_data      (csr_wr_data[CTRL_W-1:0]),
    .start_match  (start_match),
    .ctrl_q       (ctrl_q),
    .count_active (count_active)
  );

  assign evt_hit = src_event(ctrl_q.src, word_fire, start_match);
  assign step    = count_active && evt_hit;

  evc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cnt   (wr_cnt),
    .wr_ext   (wr_ext),
    .wr_data  (csr_wr_data),
    .step     (step),
    .ext_mode (ctrl_q.ext_mode),
    .cnt_q    (cnt_q),
    .ext_q    (ext_q),
    .borrow   (borrow)
  );

  evc_trace_seq #(.DATA_W(CNT_W)) u_trace (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (trc_in_valid),
    .in_addr    (trc_in_addr),
    .in_ready   (trc_in_ready),
    .trace_mode (ctrl_q.trace_mode),
    .cnt_in     (cnt_q),
    .ext_in     (ext_q),
    .out_valid  (trc_out_valid),
    .out_data   (trc_out_data),
    .out_ready  (trc_out_ready),
    .word_fire  (word_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_exc_req <= 1'b0;
    else        dbg_exc_req <= ctrl_q.exc_en && end_match;
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        case (csr_rd_sel)
          SEL_CTRL: csr_rd_data = {{PAD_W{1'b0}}, ctrl_word};
          SEL_CNT:  csr_rd_data = cnt_q;
          SEL_EXT:  csr_rd_data = ext_q;
          default:  csr_rd_data = '0;
        endcase
      end
    end else begin : g_nopad
      always_comb begin
        case (csr_rd_sel)
          SEL_CTRL: csr_rd_data = ctrl_word[CNT_W-1:0];
          SEL_CNT:  csr_rd_data = cnt_q;
          SEL_EXT:  csr_rd_data = ext_q;
          default:  csr_rd_data = '0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/evc_checker.sv
module evc_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_cnt,
  input logic         wr_ext,
  input logic         wr_ctrl,
  input logic [W-1:0] wr_data,
  input logic [15:0]  ctrl_word,
  input logic         active,
  input logic         step,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] ext_q,
  input logic         end_match,
  input logic         dbg_exc_req,
  input logic         tw_valid,
  input logic         tw_ready,
  input logic [W-1:0] tw_data,
  input logic         in_ready
);

  assert_rsvd_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (ctrl_word[15:10] == 6'd0 && ctrl_word[9:0] == $past(wr_data[9:0])));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr_cnt) |=> (cnt_q == $past(cnt_q)));

  assert_write_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data)));

  assert_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[8] && cnt_q == '0 && !wr_cnt) |=> (cnt_q == '0));

  assert_cascade_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ctrl_word[8] && cnt_q == '0 && ext_q != '0 && !wr_cnt && !wr_ext)
      |=> (cnt_q == {W{1'b1}} && ext_q == $past(ext_q) - 1'b1));

  assert_exc_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_match && ctrl_word[5]) |=> dbg_exc_req);

  assert_exc_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(end_match && ctrl_word[5]) |=> !dbg_exc_req);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_valid && !tw_ready) |=> (tw_valid && $stable(tw_data)));

  assert_single_pkt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !tw_valid);

endmodule

bind dbg_event_counter evc_checker #(.W(CNT_W)) u_evc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_cnt      (wr_cnt),
  .wr_ext      (wr_ext),
  .wr_ctrl     (wr_ctrl),
  .wr_data     (csr_wr_data),
  .ctrl_word   (ctrl_word),
  .active      (count_active),
  .step        (step),
  .cnt_q       (cnt_q),
  .ext_q       (ext_q),
  .end_match   (end_match),
  .dbg_exc_req (dbg_exc_req),
  .tw_valid    (trc_out_valid),
  .tw_ready    (trc_out_ready),
  .tw_data     (trc_out_data),
  .in_ready    (trc_in_ready)
);

// File: tb/dbg_event_counter_tb_top.sv
module dbg_event_counter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic [1:0]  csr_wr_sel = 2'd3;
  logic [31:0] csr_wr_data = '0;
  logic [1:0]  csr_rd_sel = 2'd0;
  logic [31:0] csr_rd_data;
  logic        start_match = 1'b0;
  logic        end_match = 1'b0;
  logic        dbg_exc_req;
  logic        trc_in_valid = 1'b0;
  logic [31:0] trc_in_addr = '0;
  logic        trc_in_ready;
  logic        trc_out_valid;
  logic [31:0] trc_out_data;
  logic        trc_out_ready = 1'b1;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  bit stall_en = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mc, me;

  always #10 clk = ~clk;

  dbg_event_counter dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int en, input int src, input int exc,
                                     input int tm, input int xm, input int tst);
    return 32'(en + src * 4 + exc * 32 + tm * 64 + xm * 256 + tst * 512);
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    csr_wr_en = 1'b1; csr_wr_sel = sel; csr_wr_data = d;
    @(posedge clk); #2;
    csr_wr_en = 1'b0; csr_wr_sel = 2'd3;
  endtask

  task automatic idle(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string req);
    csr_rd_sel = sel;
    @(negedge clk);
    chk(req, csr_rd_data, exp);
    @(posedge clk); #2;
  endtask

  task automatic pulse_start();
    start_match = 1'b1;
    @(posedge clk); #2;
    start_match = 1'b0;
  endtask

  task automatic model_step(input bit xm);
    if (mc > 0) mc = mc - 1;
    else if (xm && me > 0) begin mc = 32'hFFFF_FFFF; me = me - 1; end
  endtask

  task automatic send_pkt(input logic [31:0] a, input logic [1:0] tm, input bit xm);
    int n;
    bit got;
    n = 1;
    exp_q.push_back(a); tag_q.push_back("R9 addr");
    if (tm != 2'd0) begin
      exp_q.push_back(mc); tag_q.push_back("R10 count word"); n++;
    end
    if (tm[1]) begin
      exp_q.push_back(me); tag_q.push_back(xm ? "R7 ext word" : "R10 ext word"); n++;
    end
    repeat (n) model_step(xm);
    trc_in_valid = 1'b1; trc_in_addr = a;
    do begin
      @(negedge clk); got = trc_in_ready;
      @(posedge clk); #2;
    end while (!got);
    trc_in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    @(posedge clk); #2;
  endtask

  initial begin : ready_drv
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      trc_out_ready = stall_en ? (cyc % 3 != 1) : 1'b1;
    end
  end

  initial begin : monitor
    logic [31:0] e;
    string t;
    forever begin
      @(negedge clk);
      if (trc_out_valid && trc_out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R9 unexpected word", trc_out_data, 32'hXXXX_XXXX);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, trc_out_data, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset values
    @(negedge clk);
    chk("R1 trc_out_valid", {31'd0, trc_out_valid}, 32'd0);
    chk("R1 dbg_exc_req", {31'd0, dbg_exc_req}, 32'd0);
    @(posedge clk); #2;
    rd_chk(2'd0, 32'd0, "R1 ctrl");
    rd_chk(2'd1, 32'd0, "R1 count");
    rd_chk(2'd2, 32'd0, "R1 ext");

    // R2 reserved bits dropped
    wr(2'd0, 32'h0000_FC00 | cw(0, 3, 0, 0, 0, 0));
    rd_chk(2'd0, 32'h0000_000C, "R2 reserved ignored");
    wr(2'd0, 32'h0000_FFFF);
    rd_chk(2'd0, 32'h0000_03FF, "R2 readback");

    // R3 disabled holds
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    wr(2'd1, 32'd100);
    idle(10);
    rd_chk(2'd1, 32'd100, "R3 off holds");

    // R3 immediate clock counting
    wr(2'd1, 32'd1000);
    wr(2'd0, cw(1, 0, 0, 0, 0, 0));
    idle(10);
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    rd_chk(2'd1, 32'd989, "R3 immediate clock count");

    // R11 test bit has no effect
    wr(2'd1, 32'd1000);
    wr(2'd0, cw(1, 0, 0, 0, 0, 1));
    rd_chk(2'd0, 32'h0000_0201, "R11 test bit readback");
    idle(9);
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    rd_chk(2'd1, 32'd989, "R11 count unaffected");

    // R3 armed by start match
    wr(2'd1, 32'd1000);
    wr(2'd0, cw(2, 0, 0, 0, 0, 0));
    idle(5);
    rd_chk(2'd1, 32'd1000, "R3 waits for start match");
    pulse_start();
    idle(5);
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    rd_chk(2'd1, 32'd994, "R3 counts after start match");

    // R4 start-match source and null source
    wr(2'd1, 32'd50);
    wr(2'd0, cw(1, 2, 0, 0, 0, 0));
    for (int i = 0; i < 3; i++) begin
      pulse_start();
      idle(2);
    end
    rd_chk(2'd1, 32'd47, "R4 start-match source");
    wr(2'd0, cw(1, 3, 0, 0, 0, 0));
    idle(6);
    rd_chk(2'd1, 32'd47, "R4 null source");

    // R5 write wins over event
    wr(2'd0, cw(1, 0, 0, 0, 0, 0));
    wr(2'd1, 32'd500);
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    rd_chk(2'd1, 32'd499, "R5 write priority");

    // R8 exception request
    wr(2'd0, cw(0, 0, 1, 0, 0, 0));
    end_match = 1'b1;
    @(posedge clk); #2;
    end_match = 1'b0;
    @(negedge clk);
    chk("R8 request raised", {31'd0, dbg_exc_req}, 32'd1);
    @(negedge clk);
    chk("R8 request one cycle", {31'd0, dbg_exc_req}, 32'd0);
    @(posedge clk); #2;
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    end_match = 1'b1;
    @(posedge clk); #2;
    end_match = 1'b0;
    @(negedge clk);
    chk("R8 masked", {31'd0, dbg_exc_req}, 32'd0);
    @(posedge clk); #2;

    // R9 R10 full trace packets, stalled writer, trace-word source
    stall_en = 1;
    mc = 32'd200; me = 32'd7;
    wr(2'd1, mc);
    wr(2'd2, me);
    wr(2'd0, cw(1, 1, 0, 3, 0, 0));
    send_pkt(32'hA000_0010, 2'd3, 1'b0);
    send_pkt(32'hA000_0020, 2'd3, 1'b0);
    send_pkt(32'hA000_0030, 2'd3, 1'b0);
    drain();
    rd_chk(2'd1, mc, "R4 trace words counted");

    // R9 count-only and address-only modes
    wr(2'd0, cw(1, 1, 0, 1, 0, 0));
    send_pkt(32'hB000_0001, 2'd1, 1'b0);
    send_pkt(32'hB000_0002, 2'd1, 1'b0);
    drain();
    wr(2'd0, cw(1, 1, 0, 0, 0, 0));
    send_pkt(32'hC000_0003, 2'd0, 1'b0);
    drain();
    rd_chk(2'd1, mc, "R9 address-only counted");

    // R6 saturation in regular mode
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    mc = 32'd1; me = 32'd5;
    wr(2'd1, mc);
    wr(2'd2, me);
    wr(2'd0, cw(1, 1, 0, 3, 0, 0));
    send_pkt(32'hD000_0000, 2'd3, 1'b0);
    send_pkt(32'hD000_0004, 2'd3, 1'b0);
    drain();
    rd_chk(2'd1, 32'd0, "R6 floor at zero");

    // R7 cascade in extended mode
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    mc = 32'd1; me = 32'd5;
    wr(2'd1, mc);
    wr(2'd2, me);
    wr(2'd0, cw(1, 1, 0, 3, 1, 0));
    send_pkt(32'hE000_0000, 2'd3, 1'b1);
    send_pkt(32'hE000_0008, 2'd3, 1'b1);
    drain();
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    rd_chk(2'd1, mc, "R7 cascaded count");
    rd_chk(2'd2, me, "R7 extension after borrow");

    // R7 both zero holds
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    wr(2'd0, cw(1, 0, 0, 0, 1, 0));
    idle(4);
    wr(2'd0, cw(0, 0, 0, 0, 0, 0));
    rd_chk(2'd1, 32'd0, "R7 pair floor count");
    rd_chk(2'd2, 32'd0, "R7 pair floor ext");

    stall_en = 0;
    idle(2);
    chk("R9 scoreboard empty", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule